// File: doc/BRIEF.md
# Saturating Byte ALU with Sticky Flags

This block is a small signed arithmetic unit for a data path whose operands are bytes. Each accepted operation takes two signed operands and a four-bit operation code. It forms either a wrapping sum or difference, a clamped sum or difference, or a clamped magnitude of A, of A plus B or of A minus B. The result goes into an output register. Negative and zero flags are registered beside the result. A third flag records that a clamp took place, and it stays set until a dedicated clear operation is issued.

Internally the operands are first widened by one guard bit. Subtraction is formed by inverting the widened B and feeding a carry-in of one. The adder then runs at the widened width, so the true result always fits and overflow can be judged from it before clamping. A post stage picks the wrap, clamp or magnitude path and reports whether a clamp occurred. An operation is accepted on a rising clock edge at which the valid strobe is high. Its result and flags are visible from that edge on.

Top module: `clamp_alu8`

## Requirements
- R1: While reset is low, and after it, until the first accepted operation, the result is 0 and the negative, zero and saturation flags are all 0.
- R2: An operation is taken only at a rising edge where `in_valid` is 1. Its result and flags are visible after that edge. When `in_valid` is 0, the result and all flags keep their values.
- R3: Code 1 gives A+B and code 2 gives A−B. Both wrap modulo 256 and never change the saturation flag.
- R4: Code 3 gives A+B and code 4 gives A−B, clamped to the range −128..+127. A clamp sets the saturation flag.
- R5: Code 5 gives |A| clamped to +127, so A = −128 yields 127 and sets the saturation flag.
- R6: Code 6 gives |A+B| and code 7 gives |A−B|. The sum or difference is formed exactly with one guard bit and then clamped to +127, setting the saturation flag on a clamp (for example −128−127 yields 127).
- R7: On codes 1 to 7 the negative flag becomes bit 7 of the new result, and the zero flag becomes 1 exactly when the new result is 0.
- R8: The saturation flag is sticky. Once set, it stays 1 until code 8 is accepted. Code 8 clears it and leaves the result and the negative and zero flags unchanged.
- R9: Code 0, and codes 9 to 15, change neither the result nor any flag.
- R10: Codes 5, 6 and 7 never produce a negative result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 4 | Operation code (0..15) |
| opnd_a | input | 8 | Signed operand A |
| opnd_b | input | 8 | Signed operand B |
| result | output | 8 | Registered signed result |
| flag_neg | output | 1 | Negative flag |
| flag_zero | output | 1 | Zero flag |
| flag_sat | output | 1 | Sticky saturation flag |

## Verification
A clamping operation updates the negative and zero flags and sets the sticky saturation flag at the same edge. The bench provokes this with operand pairs at both range limits, including the −128 magnitude case and the −128−127 difference. Each operation is compared against a behavioural model on every clock. Back-to-back sequences then check that a later non-clamping operation keeps the saturation flag high while still refreshing the negative and zero flags, and that the clear code drops only the saturation flag. Wrapping codes that overflow are run in between to confirm they leave the saturation flag alone.

// File: rtl/clamp_alu_pkg.sv
package clamp_alu_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_IDLE    = 4'd0,
      OP_ADD_W   = 4'd1,
      OP_SUB_W   = 4'd2,
      OP_ADD_C   = 4'd3,
      OP_SUB_C   = 4'd4,
      OP_MAG_A   = 4'd5,
      OP_MAG_ADD = 4'd6,
      OP_MAG_SUB = 4'd7,
      OP_DROP_S  = 4'd8
   } alu_op_e;

   // Decoded micro-controls for one accepted operation.
   typedef struct packed {
      logic load;     // write result, N and Z
      logic inv_b;    // invert B, carry-in 1
      logic mute_b;   // force B to zero
      logic clamp;    // clamp to signed range
      logic mag;      // take magnitude before clamping
      logic drop_s;   // clear sticky saturation flag
   } alu_ctl_t;

endpackage

// File: rtl/calu_decode.sv
module calu_decode
   import clamp_alu_pkg::*;
(
   input  logic             valid_i,
   input  logic [OPC_W-1:0] code_i,
   output alu_ctl_t         ctl_o
);

   always_comb begin
      ctl_o = '0;
      if (valid_i) begin
         unique case (code_i)
            OP_ADD_W:   ctl_o.load = 1'b1;
            OP_SUB_W:   begin ctl_o.load = 1'b1; ctl_o.inv_b = 1'b1; end
            OP_ADD_C:   begin ctl_o.load = 1'b1; ctl_o.clamp = 1'b1; end
            OP_SUB_C:   begin ctl_o.load = 1'b1; ctl_o.clamp = 1'b1;
                              ctl_o.inv_b = 1'b1; end
            OP_MAG_A:   begin ctl_o.load = 1'b1; ctl_o.clamp = 1'b1;
                              ctl_o.mag = 1'b1; ctl_o.mute_b = 1'b1; end
            OP_MAG_ADD: begin ctl_o.load = 1'b1; ctl_o.clamp = 1'b1;
                              ctl_o.mag = 1'b1; end
            OP_MAG_SUB: begin ctl_o.load = 1'b1; ctl_o.clamp = 1'b1;
                              ctl_o.mag = 1'b1; ctl_o.inv_b = 1'b1; end
            OP_DROP_S:  ctl_o.drop_s = 1'b1;
            default:    ctl_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/calu_prep.sv
module calu_prep #(
   parameter int DATA_W = 8,
   localparam int EXT_W = DATA_W + 1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              inv_b_i,
   input  logic              mute_b_i,
   output logic [EXT_W-1:0]  a_ext_o,
   output logic [EXT_W-1:0]  b_ext_o,
   output logic              cin_o
);

   logic [EXT_W-1:0] b_sel;

   // One guard bit by sign extension.
   assign a_ext_o = {a_i[DATA_W-1], a_i};
   assign b_sel   = mute_b_i ? '0 : {b_i[DATA_W-1], b_i};
   assign b_ext_o = inv_b_i ? ~b_sel : b_sel;
   assign cin_o   = inv_b_i;

endmodule

// File: rtl/calu_adder.sv
module calu_adder #(
   parameter int WIDTH       = 9,
   parameter int ADDER_STYLE = 0   // 0: behavioural, 1: explicit ripple chain
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o
);

   generate
      if (ADDER_STYLE == 0) begin : g_behav
         assign sum_o = x_i + y_i + {{(WIDTH-1){1'b0}}, cin_i};
      end else begin : g_ripple
         logic [WIDTH-1:0] carry;
         assign carry[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i] = x_i[i] ^ y_i[i] ^ carry[i];
            if (i < WIDTH - 1) begin : g_cy
               assign carry[i+1] = (x_i[i] & y_i[i]) |
                                   (carry[i] & (x_i[i] ^ y_i[i]));
            end
         end
      end
   endgenerate

endmodule

// File: rtl/calu_post.sv
module calu_post #(
   parameter int DATA_W = 8,
   localparam int EXT_W = DATA_W + 1
) (
   input  logic [EXT_W-1:0]  sum_i,
   input  logic              clamp_i,
   input  logic              mag_i,
   output logic [DATA_W-1:0] value_o,
   output logic              clipped_o
);

   localparam logic signed [EXT_W-1:0] TOP_V = EXT_W'((2 ** (DATA_W - 1)) - 1);
   localparam logic signed [EXT_W-1:0] BOT_V = -TOP_V - EXT_W'(1);
   localparam logic [DATA_W-1:0] TOP_D = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] BOT_D = {1'b1, {(DATA_W-1){1'b0}}};

   logic signed [EXT_W-1:0] s;
   logic                    over_hi, over_lo, is_neg, mag_over;
   logic [DATA_W-1:0]       low_bits;

   assign s        = $signed(sum_i);
   assign low_bits = sum_i[DATA_W-1:0];
   assign is_neg   = sum_i[EXT_W-1];
   assign over_hi  = s > TOP_V;
   assign over_lo  = s < BOT_V;
   assign mag_over = is_neg ? (s < -TOP_V) : over_hi;

   always_comb begin
      value_o   = low_bits;
      clipped_o = 1'b0;
      if (clamp_i && mag_i) begin
         clipped_o = mag_over;
         if (mag_over)    value_o = TOP_D;
         else if (is_neg) value_o = -low_bits;
         else             value_o = low_bits;
      end else if (clamp_i) begin
         clipped_o = over_hi | over_lo;
         if (over_hi)      value_o = TOP_D;
         else if (over_lo) value_o = BOT_D;
      end
   end

endmodule

// File: rtl/clamp_alu8.sv
module clamp_alu8
   import clamp_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        opcode,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] result,
   output logic              flag_neg,
   output logic              flag_zero,
   output logic              flag_sat
);

   localparam int EXT_W = DATA_W + 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("clamp_alu8: DATA_W must be at least 2");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("clamp_alu8: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   alu_ctl_t          ctl;
   logic [EXT_W-1:0]  a_ext, b_ext, sum_ext;
   logic              cin;
   logic [DATA_W-1:0] value;
   logic              clipped;

   calu_decode u_dec (
      .valid_i (in_valid),
      .code_i  (opcode),
      .ctl_o   (ctl)
   );

   calu_prep #(.DATA_W(DATA_W)) u_prep (
      .a_i      (opnd_a),
      .b_i      (opnd_b),
      .inv_b_i  (ctl.inv_b),
      .mute_b_i (ctl.mute_b),
      .a_ext_o  (a_ext),
      .b_ext_o  (b_ext),
      .cin_o    (cin)
   );

   calu_adder #(.WIDTH(EXT_W), .ADDER_STYLE(ADDER_STYLE)) u_add (
      .x_i   (a_ext),
      .y_i   (b_ext),
      .cin_i (cin),
      .sum_o (sum_ext)
   );

   calu_post #(.DATA_W(DATA_W)) u_post (
      .sum_i     (sum_ext),
      .clamp_i   (ctl.clamp),
      .mag_i     (ctl.mag),
      .value_o   (value),
      .clipped_o (clipped)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result    <= '0;
         flag_neg  <= 1'b0;
         flag_zero <= 1'b0;
         flag_sat  <= 1'b0;
      end else begin
         if (ctl.load) begin
            result    <= value;
            flag_neg  <= value[DATA_W-1];
            flag_zero <= (value == '0);
            if (clipped) flag_sat <= 1'b1;
         end
         if (ctl.drop_s) flag_sat <= 1'b0;
      end
   end

endmodule

// File: rtl/clamp_alu8_chk.sv
module clamp_alu8_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        opcode,
   input logic [DATA_W-1:0] result,
   input logic              flag_neg,
   input logic              flag_zero,
   input logic              flag_sat
);

   logic loads, quiet, drops, mags;
   assign loads = in_valid && opcode >= 4'd1 && opcode <= 4'd7;
   assign drops = in_valid && opcode == 4'd8;
   assign mags  = in_valid && opcode >= 4'd5 && opcode <= 4'd7;
   assign quiet = !in_valid || opcode == 4'd0 || opcode >= 4'd9;

   // R2 / R9: idle strobe or no-op codes leave all state alone
   a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> $stable(result) && $stable(flag_neg) &&
                $stable(flag_zero) && $stable(flag_sat));

   // R8: clear code drops only S
   a_r8_drop_s: assert property (@(posedge clk) disable iff (!rst_n)
      drops |=> !flag_sat && $stable(result) && $stable(flag_neg) &&
                $stable(flag_zero));

   // R8: S is sticky
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag_sat && !drops |=> flag_sat);

   // R7: flags follow the new result
   a_r7_flags: assert property (@(posedge clk) disable iff (!rst_n)
      loads |=> (flag_zero == (result == '0)) &&
                (flag_neg == result[DATA_W-1]));

   // R10: magnitude codes never give a negative result
   a_r10_mag_sign: assert property (@(posedge clk) disable iff (!rst_n)
      mags |=> !result[DATA_W-1] && !flag_neg);

   // R3: wrapping codes never raise S
   a_r3_no_sat: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (opcode == 4'd1 || opcode == 4'd2) && !flag_sat
      |=> !flag_sat);

endmodule

bind clamp_alu8 clamp_alu8_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .opcode    (opcode),
   .result    (result),
   .flag_neg  (flag_neg),
   .flag_zero (flag_zero),
   .flag_sat  (flag_sat)
);

// File: tb/clamp_alu8_test.sv
module clamp_alu8_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic [3:0] opcode;
   logic [7:0] opnd_a, opnd_b;
   logic [7:0] result;
   logic       flag_neg, flag_zero, flag_sat;

   int  errors = 0;
   int  checks = 0;
   bit  done   = 0;

   // reference state
   int  m_res = 0;
   bit  m_n = 0, m_z = 0, m_s = 0;

   always #10 clk = ~clk;

   clamp_alu8 uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
      .flag_neg(flag_neg), .flag_zero(flag_zero), .flag_sat(flag_sat)
   );

   task automatic compare(input string tag);
      checks++;
      if ($signed(result) != m_res || flag_neg != m_n ||
          flag_zero != m_z || flag_sat != m_s) begin
         errors++;
         $display("FAIL %s: result=%0d n=%0b z=%0b s=%0b expected result=%0d n=%0b z=%0b s=%0b",
                  tag, $signed(result), flag_neg, flag_zero, flag_sat,
                  m_res, m_n, m_z, m_s);
      end
   endtask

   function automatic int wrap8(input int x);
      logic [7:0] t;
      t = x[7:0];
      return int'($signed(t));
   endfunction

   // Called at a falling edge; checks the state after the next rising edge.
   task automatic step(input bit v, input int op, input int a, input int b,
                       input string tag);
      int  x;
      int  r;
      bit  clip;
      in_valid = v;
      opcode   = op[3:0];
      opnd_a   = a[7:0];
      opnd_b   = b[7:0];
      clip = 0;
      r    = 0;
      case (op)
         1: r = wrap8(a + b);
         2: r = wrap8(a - b);
         3, 4: begin
            x = (op == 3) ? a + b : a - b;
            if (x > 127)       begin r = 127;  clip = 1; end
            else if (x < -128) begin r = -128; clip = 1; end
            else r = x;
         end
         5, 6, 7: begin
            x = (op == 5) ? a : (op == 6) ? a + b : a - b;
            if (x < 0) x = -x;
            if (x > 127) begin r = 127; clip = 1; end
            else r = x;
         end
         default: r = 0;
      endcase
      if (v && op >= 1 && op <= 7) begin
         m_res = r;
         m_n   = (r < 0);
         m_z   = (r == 0);
         if (clip) m_s = 1;
      end
      if (v && op == 8) m_s = 0;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; opcode = '0; opnd_a = '0; opnd_b = '0;
      @(negedge clk);
      in_valid = 1'b1; opcode = 4'd3; opnd_a = 8'd100; opnd_b = 8'd100;
      @(negedge clk);
      compare("R1 in reset");
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, 0, "R1 after reset");

      // R3 wrap, no saturation
      step(1, 1, 100, 100, "R3 add wrap");
      step(1, 2, -100, 100, "R3 sub wrap");
      // R4 saturating add / sub
      step(1, 3, 100, 100, "R4 add clamp high");
      step(1, 1, 1, 2, "R8 sticky after wrap add");
      step(1, 8, 50, 50, "R8 clear keeps result");
      step(1, 4, -100, 100, "R4 sub clamp low");
      step(1, 4, 20, 30, "R7 negative flag");
      step(1, 8, 0, 0, "R8 clear");
      step(1, 3, 60, 67, "R4 edge no clamp");
      step(1, 3, -64, -64, "R4 edge low no clamp");
      // R5 magnitude of A
      step(1, 5, -128, 0, "R5 mag of min");
      step(1, 8, 0, 0, "R8 clear");
      step(1, 5, -5, 99, "R5 mag small");
      // R6 magnitudes of sum / difference
      step(1, 6, -128, -128, "R6 mag sum min");
      step(1, 8, 0, 0, "R8 clear");
      step(1, 7, -128, 127, "R6 mag diff extreme");
      step(1, 8, 0, 0, "R8 clear");
      step(1, 6, -3, -4, "R6 mag sum small");
      step(1, 7, 5, 5, "R7 zero flag");
      step(1, 7, -127, 0, "R6 mag of -127");
      // R9 no-op codes
      step(1, 3, -1, -1, "R7 negative clamp op");
      step(1, 0, 100, 100, "R9 code 0");
      step(1, 12, 100, 100, "R9 code 12");
      step(1, 15, -128, 1, "R9 code 15");
      // R2 strobe low
      step(0, 3, 100, 100, "R2 strobe low");
      step(0, 8, 0, 0, "R2 strobe low clear");
      step(1, 1, 0, 0, "R7 zero on wrap");

      // mixed sweep of all codes
      for (int i = 0; i < 400; i++) begin
         int a, b, op;
         a  = int'($urandom_range(255)) - 128;
         b  = int'($urandom_range(255)) - 128;
         op = int'($urandom_range(15));
         if (i % 7 == 0) a = -128;
         if (i % 11 == 0) b = 127;
         step((i % 9) != 4, op, a, b, "R10 sweep");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule